// File: doc/BRIEF.md
# Length-Framed Stream Accumulator

This block sits on a 64-bit valid/ready stream. Every incoming frame opens with a count word. The count gives the number of payload words that follow. The block takes in that many words, sums them as unsigned 64-bit integers, and then sends a two-word result frame. The first word of the result frame is the constant 1, giving the result's own length. The second word is the sum.

Frames are handled one after another without any start pulse from software. Input and output each use a TDATA/TVALID/TREADY style handshake. The clock is the block's only timing reference. An asynchronous active-low reset is released through a short synchronizer. The datapath has a single 64-bit adder and no combinational path from input to output, so the design aims at a 4 ns clock.

Top module: `frame_accum`

## Requirements
- R1: While reset is asserted, and once it has been released, `src_ready` is 1 and `dst_valid` is 0. The block then waits for a count word.
- R2: The first word of a frame that is accepted is taken as the unsigned payload count N. The block then accepts exactly N more words. The cycle after the last of them is accepted, `src_ready` is 0.
- R3: The sum is formed as unsigned 64-bit addition and wraps modulo 2^64.
- R4: The result frame is two words. The first carries value 1 and the second carries the sum, in that order.
- R5: When the count is zero, the block sends the value 1 and then a sum of 0, and consumes no payload words.
- R6: `src_ready` is 0 whenever `dst_valid` is 1. An input word offered while a result is pending is not consumed.
- R7: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid` stays 1 and `dst_data` stays the same.
- R8: During the payload phase, one word is accepted in every cycle in which `src_valid` is 1. Every frame's sum starts at zero.
- R9: The cycle after the sum word is accepted, `dst_valid` is 0 and `src_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_data | input | 64 | Input stream word |
| src_valid | input | 1 | Input word valid |
| src_ready | output | 1 | Block accepts an input word |
| dst_data | output | 64 | Output stream word |
| dst_valid | output | 1 | Output word valid |
| dst_ready | input | 1 | Downstream accepts the output word |

## Verification
The bench sends a zero-length frame. A design that waits for a payload word here would hang, or would swallow the next frame's count word. A wrapping sum (all ones plus two, and two top-bit words) catches an adder that saturates or carries into a wider register. While the result is stalled, the bench holds a stray input word valid. A design that lets `src_ready` through would absorb that word into the next frame's sum. The bench also checks that back-to-back frames each start from zero, that four payload words take four cycles, and that a reset in the middle of a frame leaves no partial sum.

// File: rtl/frame_accum_pkg.sv
package frame_accum_pkg;
  typedef enum logic [1:0] {
    ST_GET_CNT = 2'd0,
    ST_SUM     = 2'd1,
    ST_EMIT_LN = 2'd2,
    ST_EMIT_SM = 2'd3
  } fa_state_e;
endpackage

// File: rtl/fa_rst_sync.sv
module fa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
  import frame_accum_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src_valid,
  input  logic      dst_ready,
  input  logic      cnt_is_zero,
  input  logic      last_word,
  output fa_state_e state,
  output logic      src_ready,
  output logic      dst_valid,
  output logic      load_cnt,
  output logic      acc_en,
  output logic      clr_sum
);
  fa_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_GET_CNT: if (src_valid) state_d = cnt_is_zero ? ST_EMIT_LN : ST_SUM;
      ST_SUM:     if (src_valid && last_word) state_d = ST_EMIT_LN;
      ST_EMIT_LN: if (dst_ready) state_d = ST_EMIT_SM;
      ST_EMIT_SM: if (dst_ready) state_d = ST_GET_CNT;
      default:    state_d = ST_GET_CNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_GET_CNT;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign src_ready = (state_q == ST_GET_CNT) || (state_q == ST_SUM);
  assign dst_valid = (state_q == ST_EMIT_LN) || (state_q == ST_EMIT_SM);
  assign load_cnt  = (state_q == ST_GET_CNT) && src_valid;
  assign acc_en    = (state_q == ST_SUM) && src_valid;
  assign clr_sum   = (state_q == ST_EMIT_SM) && dst_ready;
endmodule

// File: rtl/fa_counter.sv
module fa_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? load_val : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/fa_accum.sv
module fa_accum #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] sum_q, sum_d;
  logic              sum_en;

  always_comb begin
    sum_en = clr || en;
    sum_d  = clr ? '0 : (sum_q + addend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum = sum_q;
endmodule

// File: rtl/frame_accum.sv
module frame_accum
  import frame_accum_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_valid,
  input  logic              dst_ready
);
  localparam logic [DATA_W-1:0] RES_LEN = DATA_W'(1);

  logic              rst_sync_n;
  fa_state_e         state;
  logic              load_cnt, acc_en, clr_sum, last_word;
  logic [DATA_W-1:0] sum;

  fa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  fa_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .src_valid   (src_valid),
    .dst_ready   (dst_ready),
    .cnt_is_zero (src_data == '0),
    .last_word   (last_word),
    .state       (state),
    .src_ready   (src_ready),
    .dst_valid   (dst_valid),
    .load_cnt    (load_cnt),
    .acc_en      (acc_en),
    .clr_sum     (clr_sum)
  );

  fa_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (load_cnt),
    .load_val (src_data),
    .dec      (acc_en),
    .last     (last_word)
  );

  fa_accum #(.DATA_W(DATA_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (clr_sum),
    .en     (acc_en),
    .addend (src_data),
    .sum    (sum)
  );

  assign dst_data = (state == ST_EMIT_LN) ? RES_LEN : sum;
endmodule

// File: rtl/frame_accum_chk.sv
module frame_accum_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ready,
  input logic [DATA_W-1:0] dst_data,
  input logic              dst_valid,
  input logic              dst_ready
);
  logic want_sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      want_sum_q <= 1'b0;
    else if (dst_valid && dst_ready) want_sum_q <= !want_sum_q;
  end

  // R6
  a_r6_no_input_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> !src_ready);

  // R7
  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

  // R4
  a_r4_first_word_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !want_sum_q) |-> (dst_data == DATA_W'(1)));

  // R9
  a_r9_back_to_count: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && want_sum_q) |=> (!dst_valid && src_ready));
endmodule

bind frame_accum frame_accum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_ready (src_ready),
  .dst_data  (dst_data),
  .dst_valid (dst_valid),
  .dst_ready (dst_ready)
);

// File: tb/frame_accum_tb.sv
module frame_accum_tb;
  localparam int NV = 6;
  localparam logic [63:0] V_LEN [NV] = '{64'd1, 64'd3, 64'd4, 64'd2, 64'd0, 64'd4};
  localparam logic [63:0] V_D [NV][4] = '{
    '{64'd5, 64'd0, 64'd0, 64'd0},
    '{64'd1, 64'd2, 64'd3, 64'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd0, 64'd0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 64'd0},
    '{64'd0, 64'd0, 64'd0, 64'd0},
    '{64'd10, 64'd20, 64'd30, 64'd40}};
  localparam logic [63:0] V_EXP [NV] = '{64'd5, 64'd6, 64'd1, 64'd0, 64'd0, 64'd100};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [63:0] dst_data;
  logic        dst_valid;
  logic        dst_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_accum u_dut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .dst_data(dst_data), .dst_valid(dst_valid),
    .dst_ready(dst_ready));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the word is taken.
  task automatic push(input logic [63:0] d);
    src_valid = 1'b1;
    src_data  = d;
    while (!src_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pull(output logic [63:0] w);
    dst_ready = 1'b1;
    while (!dst_valid) @(negedge clk);
    w = dst_data;
    @(posedge clk);
    @(negedge clk);
    dst_ready = 1'b0;
  endtask

  task automatic frame(input logic [63:0] len, input logic [63:0] d [4], input logic [63:0] exp);
    logic [63:0] w;
    push(len);
    for (int k = 0; k < int'(len); k++) push(d[k]);
    src_valid = 1'b0;
    chk(!src_ready && dst_valid, "R2/R5 ready low after payload", {63'd0, src_ready}, 64'd0);
    pull(w);
    chk(w == 64'd1, "R4 first result word", w, 64'd1);
    pull(w);
    chk(w == exp, "R3/R4/R5/R8 sum word", w, exp);
    chk(src_ready && !dst_valid, "R9 back to count", {62'd0, src_ready, dst_valid}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] w;
    int t0;
    repeat (3) @(negedge clk);
    chk(src_ready && !dst_valid, "R1 during reset", {62'd0, src_ready, dst_valid}, 64'd2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(src_ready && !dst_valid, "R1 after reset", {62'd0, src_ready, dst_valid}, 64'd2);

    // vector table
    for (int i = 0; i < NV; i++) frame(V_LEN[i], V_D[i], V_EXP[i]);

    // R8: four payload words in four cycles
    push(64'd4);
    t0 = cyc;
    for (int k = 0; k < 4; k++) push(64'(k + 1));
    src_valid = 1'b0;
    chk(cyc - t0 == 4, "R8 one word per cycle", 64'(cyc - t0), 64'd4);
    // R6/R7: stall with a stray input word offered
    src_valid = 1'b1;
    src_data  = 64'd77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dst_valid && dst_data == 64'd1 && !src_ready, "R6/R7 stalled length word", dst_data, 64'd1);
    end
    src_valid = 1'b0;
    pull(w);
    chk(w == 64'd1, "R4 length after stall", w, 64'd1);
    repeat (2) @(negedge clk);
    chk(dst_valid && dst_data == 64'd10, "R7 stalled sum held", dst_data, 64'd10);
    pull(w);
    chk(w == 64'd10, "R3 sum after stall", w, 64'd10);
    // stray word must not have leaked in
    frame(V_LEN[0], V_D[0], V_EXP[0]);

    // R1: reset mid-frame discards partial work
    push(64'd3);
    push(64'd1000);
    src_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(src_ready && !dst_valid, "R1 reset mid-frame", {62'd0, src_ready, dst_valid}, 64'd2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    frame(V_LEN[1], V_D[1], V_EXP[1]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule